// File: doc/BRIEF.md
# Programmable Power Rail Sequencer

This block drives the enable pins of four supply rails (two switching converters and two linear regulators) from one master enable level. When the master enable goes high, each rail is switched on after its own power-up delay. When the enable goes low, each rail is switched off after its own power-down delay. Every delay is counted from that single enable transition, not from the rail before it. The logic runs from a free-running local oscillator (`clk`). The master enable is asynchronous to that clock, so it passes through a two-stage synchronizer before the sequencer acts on it.

Each rail has two 3-bit delay codes, one per direction, held in a small write-only register file. Each code maps to a value in a fixed, non-linear table of half-millisecond steps. The tick count for a step comes from the `CLK_HZ` parameter, so half-millisecond resolution is exact. Codes 6 and 7 select the rail's own default delay. The reset value of every code is 7. With all codes at reset, the rails switch in the order converter 1, converter 2, regulator 1, regulator 2, and the down delays equal the up delays. The register port has no back-pressure: a write is taken on every clock edge on which `cfg_we` is high.

A status output, `seq_done`, reports when every rail has reached the level the latched enable asks for. If the enable reverses during a sequence, all pending counts are dropped and a new sequence in the new direction starts from that transition.

Top module: `power_rail_sequencer`

## Requirements
- R1: While `rst_n` is low, `rail_en` is 0 and every delay code returns to 7. After reset, with `en_in` low, `rail_en` is 0 and `seq_done` is 1.
- R2: After `en_in` rises, rail i goes high exactly on the (4 + U×T)-th rising clock edge, counting the first edge that samples the new level as edge 1. T is CLK_HZ/2000 and U is the up step count for the code: code 0→2, 1→3, 2→4, 3→6, 4→12, 5→22 half-milliseconds.
- R3: After `en_in` falls, rail i goes low on the same edge count (4 + U×T), using the down step counts: code 0→0, 1→1, 2→2, 3→4, 4→10, 5→20 half-milliseconds.
- R4: Codes 6 and 7 select the rail's default in both directions: rail 0 → 3, rail 1 → 4, rail 2 → 6, rail 3 → 12 half-milliseconds.
- R5: A write with `cfg_we` high stores `cfg_data` as a delay code. `cfg_addr[2]` selects the direction (0 = power-up, 1 = power-down) and `cfg_addr[1:0]` selects the rail (0, 1 = converters; 2, 3 = regulators).
- R6: A code written while a sequence is running does not change that sequence. It takes effect from the next enable transition.
- R7: If `en_in` reverses during a sequence, every pending count is dropped and all rails are timed from the new transition. A rail already at the new level stays unchanged.
- R8: A delay of zero steps changes the rail on edge 4, the earliest possible edge.
- R9: `seq_done` is low while any rail still differs from the latched enable level. It is high once all rails match, and the rails do not move while it stays high.
- R10: With reset codes, the rails switch one at a time in the order rail 0, 1, 2, 3 in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running sequencer clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| en_in | input | 1 | Master enable, asynchronous level |
| cfg_we | input | 1 | Delay-code write strobe |
| cfg_addr | input | 3 | Bit 2 direction (1 = down), bits 1:0 rail index |
| cfg_data | input | 3 | Delay code to store |
| rail_en | output | 4 | Rail enables; bit i drives rail i |
| seq_done | output | 1 | All rails match the latched enable level |

## Verification
The checker assumes that `cfg_addr` and `cfg_data` hold known values on every edge where `cfg_we` is high, and that `en_in` is never unknown after reset. The bench meets both conditions by driving every input from one procedural thread on the falling clock edge and releasing the write strobe one cycle after it raises it. The direction properties also rely on the synchronizer seeing a clean level: the bench changes `en_in` only between edges, and it holds each level long enough for a sequence to finish, except in the deliberate reversal test.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  localparam int unsigned N_RAILS = 4;
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned UNIT_W  = 5;
  localparam int unsigned IDX_W   = $clog2(N_RAILS);
  localparam int unsigned ADDR_W  = IDX_W + 1;
  localparam int unsigned MAX_UNITS = 22;

  typedef logic [CODE_W-1:0] dly_code_t;
  typedef logic [UNIT_W-1:0] units_t;

  // default per rail, in half-millisecond steps
  function automatic units_t dflt_units(input logic [IDX_W-1:0] rail);
    case (rail)
      2'd0:    return units_t'(3);
      2'd1:    return units_t'(4);
      2'd2:    return units_t'(6);
      default: return units_t'(12);
    endcase
  endfunction

  function automatic units_t up_units(input dly_code_t c, input logic [IDX_W-1:0] rail);
    case (c)
      3'd0:    return units_t'(2);
      3'd1:    return units_t'(3);
      3'd2:    return units_t'(4);
      3'd3:    return units_t'(6);
      3'd4:    return units_t'(12);
      3'd5:    return units_t'(22);
      default: return dflt_units(rail);
    endcase
  endfunction

  function automatic units_t dn_units(input dly_code_t c, input logic [IDX_W-1:0] rail);
    case (c)
      3'd0:    return units_t'(0);
      3'd1:    return units_t'(1);
      3'd2:    return units_t'(2);
      3'd3:    return units_t'(4);
      3'd4:    return units_t'(10);
      3'd5:    return units_t'(20);
      default: return dflt_units(rail);
    endcase
  endfunction
endpackage

// File: rtl/rseq_cfg_regs.sv
module rseq_cfg_regs
  import rseq_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [ADDR_W-1:0]              cfg_addr,
  input  logic [CODE_W-1:0]              cfg_data,
  output logic [N_RAILS-1:0][CODE_W-1:0] up_code,
  output logic [N_RAILS-1:0][CODE_W-1:0] dn_code
);
  localparam logic [CODE_W-1:0] RST_CODE = '1;

  for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
    logic hit;
    assign hit = cfg_we && (cfg_addr[IDX_W-1:0] == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        up_code[g] <= RST_CODE;
        dn_code[g] <= RST_CODE;
      end else if (hit) begin
        if (cfg_addr[ADDR_W-1]) dn_code[g] <= cfg_data;
        else                    up_code[g] <= cfg_data;
      end
    end
  end
endmodule

// File: rtl/rseq_en_sync.sv
module rseq_en_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic en_in,
  output logic en_lvl,
  output logic en_new,
  output logic start
);
  logic s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      en_lvl <= 1'b0;
    end else begin
      s1     <= en_in;
      s2     <= s1;
      en_lvl <= s2;
    end
  end

  assign en_new = s2;
  assign start  = s2 ^ en_lvl;
endmodule

// File: rtl/rseq_rail_timer.sv
module rseq_rail_timer
  import rseq_pkg::*;
#(
  parameter int unsigned RAIL_IDX = 0,
  parameter int unsigned TPH      = 1,
  parameter int unsigned CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              target,
  input  logic [CODE_W-1:0] up_code,
  input  logic [CODE_W-1:0] dn_code,
  output logic              rail_out
);
  units_t           units;
  logic [CNT_W-1:0] ticks;
  logic [CNT_W-1:0] cnt;
  logic             active;
  logic             dir;

  always_comb begin
    units = target ? up_units(up_code, IDX_W'(RAIL_IDX))
                   : dn_units(dn_code, IDX_W'(RAIL_IDX));
    ticks = CNT_W'(units) * CNT_W'(TPH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      active   <= 1'b0;
      dir      <= 1'b0;
      rail_out <= 1'b0;
    end else if (start) begin
      dir <= target;
      cnt <= ticks;
      active <= (rail_out != target);
    end else if (active) begin
      if (cnt == '0) begin
        rail_out <= dir;
        active   <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/power_rail_sequencer.sv
module power_rail_sequencer
  import rseq_pkg::*;
#(
  parameter int unsigned CLK_HZ = 2_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_in,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [CODE_W-1:0]  cfg_data,
  output logic [N_RAILS-1:0] rail_en,
  output logic               seq_done
);
  localparam int unsigned TPH_RAW = CLK_HZ / 2000;
  localparam int unsigned TPH     = (TPH_RAW < 1) ? 1 : TPH_RAW;
  localparam int unsigned CNT_W   = $clog2(MAX_UNITS * TPH + 1);

  logic [N_RAILS-1:0][CODE_W-1:0] up_code;
  logic [N_RAILS-1:0][CODE_W-1:0] dn_code;
  logic en_lvl, en_new, start;

  rseq_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .up_code(up_code), .dn_code(dn_code)
  );

  rseq_en_sync u_sync (
    .clk(clk), .rst_n(rst_n), .en_in(en_in),
    .en_lvl(en_lvl), .en_new(en_new), .start(start)
  );

  for (genvar g = 0; g < N_RAILS; g++) begin : g_timer
    rseq_rail_timer #(.RAIL_IDX(g), .TPH(TPH), .CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(start), .target(en_new),
      .up_code(up_code[g]), .dn_code(dn_code[g]), .rail_out(rail_en[g])
    );
  end

  assign seq_done = (rail_en == {N_RAILS{en_lvl}});
endmodule

// File: rtl/rseq_checker.sv
module rseq_checker
  import rseq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [N_RAILS-1:0] rail_en,
  input logic               seq_done,
  input logic               en_lvl,
  input logic               cfg_we,
  input logic [ADDR_W-1:0]  cfg_addr,
  input logic [CODE_W-1:0]  cfg_data
);
  AST_RESET_RAILS_OFF: assert property (@(posedge clk) !rst_n |-> rail_en == '0); // R1
  AST_RISE_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ((rail_en & ~$past(rail_en)) != '0) |-> en_lvl); // R2
  AST_FALL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((~rail_en & $past(rail_en)) != '0) |-> !en_lvl); // R3
  AST_DONE_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_done) |-> (en_lvl != $past(en_lvl))); // R9
  AST_STABLE_WHILE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seq_done) && (en_lvl == $past(en_lvl))) |-> $stable(rail_en)); // R9
  AST_CFG_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !$isunknown({cfg_addr, cfg_data})); // R5
endmodule

bind power_rail_sequencer rseq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .seq_done(seq_done),
  .en_lvl(en_lvl), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data)
);

// File: tb/power_rail_sequencer_bench.sv
module power_rail_sequencer_bench;
  localparam int TPH = 4;
  localparam int CLK_HZ = TPH * 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_in = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [2:0] cfg_data = '0;
  logic [3:0] rail_en;
  logic seq_done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  power_rail_sequencer #(.CLK_HZ(CLK_HZ)) u_power_rail_sequencer (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .rail_en(rail_en), .seq_done(seq_done)
  );

  // {rail[1:0], up, code[2:0], half-ms steps[4:0]}
  localparam logic [10:0] VEC [14] = '{
    {2'd0, 1'b1, 3'd0, 5'd2},  {2'd0, 1'b0, 3'd0, 5'd0},
    {2'd1, 1'b1, 3'd5, 5'd22}, {2'd1, 1'b0, 3'd5, 5'd20},
    {2'd2, 1'b1, 3'd3, 5'd6},  {2'd2, 1'b0, 3'd1, 5'd1},
    {2'd3, 1'b1, 3'd4, 5'd12}, {2'd3, 1'b0, 3'd2, 5'd2},
    {2'd0, 1'b1, 3'd7, 5'd3},  {2'd0, 1'b0, 3'd6, 5'd3},
    {2'd2, 1'b1, 3'd1, 5'd3},  {2'd2, 1'b0, 3'd4, 5'd10},
    {2'd3, 1'b1, 3'd6, 5'd12}, {2'd3, 1'b0, 3'd3, 5'd4}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write_code(input logic [2:0] a, input logic [2:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    cycle();
    cfg_we = 1'b0;
  endtask

  task automatic measure(input int r, input logic tgt, output int got);
    got = -1;
    for (int n = 1; n <= 400; n++) begin
      cycle();
      if (rail_en[r] == tgt) begin got = n; break; end
    end
  endtask

  task automatic wait_done();
    for (int k = 0; k < 4; k++) cycle();
    for (int k = 0; k < 400 && !seq_done; k++) cycle();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en_in = 1'b0; cfg_we = 1'b0;
    cycle(); cycle();
    rst_n = 1'b1;
    cycle();
  endtask

  // default-code run: record the edge on which each rail reaches tgt
  task automatic default_run(input logic tgt, input string tag);
    int hit [4];
    int exp [4];
    exp = '{16, 20, 28, 52};
    for (int r = 0; r < 4; r++) hit[r] = -1;
    en_in = tgt;
    for (int n = 1; n <= 60; n++) begin
      cycle();
      for (int r = 0; r < 4; r++)
        if (hit[r] < 0 && rail_en[r] == tgt) hit[r] = n;
      if (n == 10) chk(seq_done == 1'b0, "R9 busy", int'(seq_done), 0);
    end
    for (int r = 0; r < 4; r++) chk(hit[r] == exp[r], tag, hit[r], exp[r]); // R4
    chk(hit[0] < hit[1] && hit[1] < hit[2] && hit[2] < hit[3], "R10 order", hit[3], 52);
    chk(seq_done == 1'b1, "R9 done", int'(seq_done), 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int got;
    int r3_hit;
    logic [1:0] rail;
    logic up;
    logic [2:0] code;
    logic [4:0] units;

    // R1: reset state
    cycle();
    chk(rail_en == 4'd0, "R1 rails in reset", int'(rail_en), 0);
    do_reset();
    chk(rail_en == 4'd0, "R1 rails off", int'(rail_en), 0);
    chk(seq_done == 1'b1, "R1 done", int'(seq_done), 1);

    // R4 / R10: reset codes in both directions
    default_run(1'b1, "R4 up default");
    default_run(1'b0, "R4 down default");

    // table: R2 / R3 / R5 / R8
    for (int i = 0; i < 14; i++) begin
      {rail, up, code, units} = VEC[i];
      write_code({~up, rail}, code);
      en_in = up;
      measure(int'(rail), up, got);
      chk(got == 4 + int'(units) * TPH, up ? "R2 up delay (R5 addr)" : "R3 down delay (R5 addr, R8)",
          got, 4 + int'(units) * TPH);
      wait_done();
    end

    // R6: a write during a sequence waits for the next edge
    do_reset();
    en_in = 1'b1;
    r3_hit = -1;
    for (int n = 1; n <= 60; n++) begin
      cycle();
      if (r3_hit < 0 && rail_en[3]) r3_hit = n;
      if (n == 5) begin cfg_we = 1'b1; cfg_addr = 3'b011; cfg_data = 3'd0; end
      if (n == 6) cfg_we = 1'b0;
    end
    chk(r3_hit == 52, "R6 old code kept", r3_hit, 52);
    en_in = 1'b0;
    wait_done();
    en_in = 1'b1;
    measure(3, 1'b1, got);
    chk(got == 12, "R6 new code used", got, 12);
    en_in = 1'b0;
    wait_done();

    // R7: reverse mid-sequence (rail 3 up code now 0 -> edge 12)
    en_in = 1'b1;
    for (int n = 1; n <= 22; n++) cycle();
    chk(rail_en == 4'b1011, "R7 before abort", int'(rail_en), 11);
    en_in = 1'b0;
    for (int n = 1; n <= 40; n++) begin
      cycle();
      if (n == 10) chk(seq_done == 1'b0, "R7 busy", int'(seq_done), 0);
    end
    chk(rail_en == 4'b1000, "R7 after abort", int'(rail_en), 8);
    wait_done();
    chk(rail_en == 4'b0000, "R7 all off", int'(rail_en), 0);
    chk(seq_done == 1'b1, "R9 done after abort", int'(seq_done), 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule